// File: doc/BRIEF.md
# CPU Memory Bus Interface Unit

This unit links a processor's internal data bus to an external system bus. It holds two registers. The address register is loaded from the internal bus and drives the external address lines. The data register is loaded from either side through a selector that the read request controls. A small sequencer runs one read or one write transaction at a time. It raises a read or write request and waits for the memory's completion acknowledge. That acknowledge passes through a two-flop synchronizer first.

A transaction has a fixed order. The CPU loads the address register and, for a write, the data register. It then pulses `start` with a direction bit. The sequencer holds the request until the synchronized acknowledge arrives. It then spends one cycle in a completion state, pulses `done`, and returns to idle. For a read, the data register takes the external data only in the cycle the synchronized acknowledge is seen. The CPU can then present the captured value on the internal bus with an output enable. A cycle-limit timeout can end a wait that gets no acknowledge.

Top module: `mem_bus_iface`

## Requirements
- R1: A high `mar_ld` at a rising edge loads `ibus_in[AW-1:0]` into the address register. `ext_addr` shows that register, and nothing on the external side changes it.
- R2: A high `mdr_ld` at a rising edge, while no read is pending, loads `ibus_in` into the data register.
- R3: During a pending read, the data register loads `ext_din` only when the synchronized acknowledge is high, and `ext_din` is ignored at all other times. The acknowledge is `mfc`. If `mfc` rises at a falling edge during the wait, `done` is high three rising edges later.
- R4: While `mdr_oe` is high, `ibus_out` equals the data register and `ibus_vld` is 1. While `mdr_oe` is low, `ibus_out` is 0 and `ibus_vld` is 0.
- R5: `ext_oe` is high only while `wr_req` is high, and then `ext_dout` equals the data register. At all other times `ext_dout` is 0, so the external bus is never driven during a read.
- R6: An accepted `start` raises `rd_req` on the next cycle when `dir_wr` is 0, and raises `wr_req` when `dir_wr` is 1. `rd_req` and `wr_req` are never high together.
- R7: `done` is a one-cycle pulse. In the cycle after it, `busy` is low.
- R8: `busy` is high whenever the sequencer is not idle. A `start` that arrives while busy has no effect on the running transaction.
- R9: When the `TO_EN` parameter is 1, a wait with no acknowledge lasts `TO_LIMIT` cycles. The unit then returns to idle without a `done` pulse and sets `timeout_err`. The next accepted `start` clears `timeout_err`.
- R10: A synchronous `rst` clears the address register, the data register, both requests, `timeout_err` and the synchronizer, and returns the sequencer to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Transaction request pulse |
| dir_wr | input | 1 | Direction: 1 for write, 0 for read |
| mar_ld | input | 1 | Load address register from the internal bus |
| mdr_ld | input | 1 | Load data register from the internal bus |
| mdr_oe | input | 1 | Drive the data register onto the internal bus |
| ibus_in | input | DW | Internal bus value into the unit |
| ibus_out | output | DW | Internal bus value out of the unit, 0 when released |
| ibus_vld | output | 1 | `ibus_out` is being driven |
| ext_addr | output | AW | External address lines |
| ext_din | input | DW | External data into the unit |
| ext_dout | output | DW | External data out of the unit |
| ext_oe | output | 1 | External data drive enable |
| rd_req | output | 1 | Read request to memory |
| wr_req | output | 1 | Write request to memory |
| mfc | input | 1 | Completion acknowledge from memory (asynchronous) |
| done | output | 1 | Transaction completed pulse |
| busy | output | 1 | Sequencer not idle |
| timeout_err | output | 1 | Last transaction timed out |

## Verification
Some rules are checked by assertions on every cycle:
- the two requests never overlap;
- the external drive is off and zero whenever no write is pending;
- the internal output is released whenever its enable is low;
- `done` lasts one cycle and leaves the unit idle;
- an address load appears on the address lines one cycle later.

Other behaviour needs the bench's scenarios:
- the three-cycle acknowledge latency;
- the data register ignoring external data before the acknowledge;
- a `start` during a transaction being dropped;
- the exact timeout length;
- the values that come back after each transaction.

// File: rtl/mem_bus_iface.sv
module mem_bus_iface #(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter bit TO_EN = 1'b1,
  parameter int TO_LIMIT = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          dir_wr,
  input  logic          mar_ld,
  input  logic          mdr_ld,
  input  logic          mdr_oe,
  input  logic [DW-1:0] ibus_in,
  output logic [DW-1:0] ibus_out,
  output logic          ibus_vld,
  output logic [AW-1:0] ext_addr,
  input  logic [DW-1:0] ext_din,
  output logic [DW-1:0] ext_dout,
  output logic          ext_oe,
  output logic          rd_req,
  output logic          wr_req,
  input  logic          mfc,
  output logic          done,
  output logic          busy,
  output logic          timeout_err
);
  localparam int CW = $clog2(TO_LIMIT + 1);

  typedef enum logic [1:0] {IDLE, RD_WAIT, WR_WAIT, FIN} st_t;

  st_t           st;
  logic          mfc_s1, mfc_s2;
  logic [AW-1:0] mar;
  logic [DW-1:0] mdr;
  logic [DW-1:0] mdr_d;
  logic          mdr_en;
  logic          tmo;
  logic          err_q;

  assign rd_req      = (st == RD_WAIT);
  assign wr_req      = (st == WR_WAIT);
  assign busy        = (st != IDLE);
  assign done        = (st == FIN);
  assign mdr_d       = rd_req ? ext_din : ibus_in;
  assign mdr_en      = rd_req ? mfc_s2 : mdr_ld;
  assign ext_addr    = mar;
  assign ext_oe      = wr_req;
  assign ext_dout    = wr_req ? mdr : '0;
  assign ibus_vld    = mdr_oe;
  assign ibus_out    = mdr_oe ? mdr : '0;
  assign timeout_err = err_q;

  generate
    if (TO_EN) begin : g_tmo
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !(rd_req || wr_req)) cnt <= '0;
        else                            cnt <= cnt + 1'b1;
      end
      assign tmo = (cnt == CW'(TO_LIMIT - 1));
    end else begin : g_no_tmo
      assign tmo = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= IDLE;
      mfc_s1 <= 1'b0;
      mfc_s2 <= 1'b0;
      mar    <= '0;
      mdr    <= '0;
      err_q  <= 1'b0;
    end else begin
      mfc_s1 <= mfc;
      mfc_s2 <= mfc_s1;
      if (mar_ld) mar <= ibus_in[AW-1:0];
      if (mdr_en) mdr <= mdr_d;
      case (st)
        IDLE: if (start) begin
          st    <= dir_wr ? WR_WAIT : RD_WAIT;
          err_q <= 1'b0;
        end
        RD_WAIT, WR_WAIT: begin
          if (mfc_s2) st <= FIN;
          else if (tmo) begin
            st    <= IDLE;
            err_q <= 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module mem_bus_iface_chk #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          mar_ld,
  input logic          mdr_oe,
  input logic [DW-1:0] ibus_in,
  input logic [DW-1:0] ibus_out,
  input logic          ibus_vld,
  input logic [AW-1:0] ext_addr,
  input logic [DW-1:0] ext_dout,
  input logic          ext_oe,
  input logic          rd_req,
  input logic          wr_req,
  input logic          done,
  input logic          busy
);
  a_r6_req_excl: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));

  a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (!ext_oe && ext_dout == '0));

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !wr_req |-> (ext_dout == '0 && !ext_oe));

  a_r4_release: assert property (@(posedge clk) disable iff (rst)
    !mdr_oe |-> (ibus_out == '0 && !ibus_vld));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

  a_r1_addr_load: assert property (@(posedge clk) disable iff (rst)
    mar_ld |=> (ext_addr == $past(ibus_in[AW-1:0])));

  a_r8_busy_on_req: assert property (@(posedge clk) disable iff (rst)
    (rd_req || wr_req || done) |-> busy);
endmodule

bind mem_bus_iface mem_bus_iface_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mar_ld(mar_ld), .mdr_oe(mdr_oe), .ibus_in(ibus_in),
  .ibus_out(ibus_out), .ibus_vld(ibus_vld), .ext_addr(ext_addr),
  .ext_dout(ext_dout), .ext_oe(ext_oe), .rd_req(rd_req), .wr_req(wr_req),
  .done(done), .busy(busy)
);

// File: tb/mem_bus_iface_test.sv
`timescale 1ns/1ps
module mem_bus_iface_test;
  localparam int DW = 16;
  localparam int AW = 12;
  localparam int LIM = 20;
  localparam int NV = 6;

  localparam logic [DW+AW:0] VEC [NV] = '{
    {1'b1, 12'h123, 16'hBEEF},
    {1'b0, 12'h123, 16'h1234},
    {1'b1, 12'hFFF, 16'hFFFF},
    {1'b0, 12'h000, 16'h0000},
    {1'b1, 12'hA5A, 16'h0001},
    {1'b0, 12'h5A5, 16'h8000}
  };

  logic clk = 1'b0;
  logic rst, start, dir_wr, mar_ld, mdr_ld, mdr_oe, mfc;
  logic [DW-1:0] ibus_in, ext_din;
  logic [DW-1:0] ibus_out, ext_dout;
  logic [AW-1:0] ext_addr;
  logic ibus_vld, ext_oe, rd_req, wr_req, done, busy, timeout_err;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  mem_bus_iface #(.DW(DW), .AW(AW), .TO_EN(1'b1), .TO_LIMIT(LIM)) uut (
    .clk(clk), .rst(rst), .start(start), .dir_wr(dir_wr), .mar_ld(mar_ld),
    .mdr_ld(mdr_ld), .mdr_oe(mdr_oe), .ibus_in(ibus_in), .ibus_out(ibus_out),
    .ibus_vld(ibus_vld), .ext_addr(ext_addr), .ext_din(ext_din),
    .ext_dout(ext_dout), .ext_oe(ext_oe), .rd_req(rd_req), .wr_req(wr_req),
    .mfc(mfc), .done(done), .busy(busy), .timeout_err(timeout_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_addr(input logic [AW-1:0] a);
    ibus_in = DW'(a); mar_ld = 1; tick(1); mar_ld = 0;
  endtask

  task automatic load_data(input logic [DW-1:0] d);
    ibus_in = d; mdr_ld = 1; tick(1); mdr_ld = 0;
  endtask

  task automatic ack_and_wait(input string req);
    int n = 0;
    mfc = 1;
    while (!done && n < 10) begin tick(1); n++; end
    chk(req, n, 3);
    mfc = 0;
    tick(1);
    chk("R7", {done, busy}, 2'b00);
    tick(3);
  endtask

  task automatic read_back(input string req, input logic [DW-1:0] exp);
    mdr_oe = 1; #1;
    chk(req, {ibus_vld, ibus_out}, {1'b1, exp});
    mdr_oe = 0; #1;
    chk("R4", {ibus_vld, ibus_out}, '0);
  endtask

  initial begin
    tick(200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_run();
  end

  initial begin
    rst = 1; start = 0; dir_wr = 0; mar_ld = 0; mdr_ld = 0; mdr_oe = 0;
    mfc = 0; ibus_in = '0; ext_din = '0;
    tick(3);
    rst = 0;
    tick(1);
    chk("R10", {rd_req, wr_req, busy, done, ext_oe, timeout_err}, '0);
    chk("R10", ext_addr, 0);
    read_back("R10", '0);

    for (int v = 0; v < NV; v++) begin
      logic wr;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      {wr, a, d} = VEC[v];
      load_addr(a);
      chk("R1", ext_addr, a);
      if (wr) begin
        load_data(d);
        dir_wr = 1; start = 1; tick(1); start = 0;
        chk("R6", {rd_req, wr_req, busy}, 3'b011);
        chk("R5", {ext_oe, ext_dout}, {1'b1, d});
        chk("R1", ext_addr, a);
        ack_and_wait("R3");
        chk("R5", {ext_oe, ext_dout}, '0);
      end else begin
        ext_din = ~d;
        dir_wr = 0; start = 1; tick(1); start = 0;
        chk("R6", {rd_req, wr_req, busy}, 3'b101);
        chk("R5", {ext_oe, ext_dout}, '0);
        tick(2);
        read_back("R3", VEC[v-1][DW-1:0]);
        ext_din = d;
        ack_and_wait("R3");
        ext_din = ~d;
        tick(1);
        read_back("R3", d);
      end
    end

    // R2: direct internal load and read back
    load_data(16'h5AA5);
    read_back("R2", 16'h5AA5);

    // R8: start while busy is dropped
    load_addr(12'h321);
    ext_din = 16'hC3C3;
    dir_wr = 0; start = 1; tick(1); start = 0;
    tick(1);
    dir_wr = 1; start = 1; tick(1); start = 0; dir_wr = 0;
    chk("R8", {rd_req, wr_req, busy}, 3'b101);
    ack_and_wait("R8");
    chk("R8", {rd_req, wr_req, busy}, 3'b000);
    read_back("R8", 16'hC3C3);

    // R9: timeout
    begin
      int n = 0;
      bit saw_done = 0;
      dir_wr = 1; start = 1; tick(1); start = 0; n = 1;
      while (busy && n < 4 * LIM) begin
        if (done) saw_done = 1;
        tick(1); n++;
      end
      chk("R9", n, LIM + 1);
      chk("R9", {timeout_err, saw_done}, 2'b10);
      tick(2);
      dir_wr = 0; start = 1; tick(1); start = 0;
      chk("R9", {timeout_err, rd_req}, 2'b01);
      ack_and_wait("R9");
    end

    // R10: reset during a pending write
    load_addr(12'h777);
    load_data(16'h7777);
    dir_wr = 1; start = 1; tick(1); start = 0;
    rst = 1; tick(1); rst = 0;
    chk("R10", {rd_req, wr_req, busy, ext_oe}, '0);
    chk("R10", ext_addr, 0);
    read_back("R10", '0);

    tick(2);
    finish_run();
  end
endmodule